// File: doc/BRIEF.md
# Posted-Write Ordering Dispatcher

This block sits between a link receive path and two application ports that each run at half the link rate. It accepts one posted memory-write descriptor per clock (requester ID, address, length, tag, a relaxed-ordering flag and an ID-ordering flag) and steers each descriptor to one of the two ports. Neither port can keep pace with the link on its own, so both must carry traffic, including strongly ordered writes.

Because the two ports reach memory along independent paths, the block keeps a scoreboard of every write it has issued and not yet seen retired. A port signals retirement with a pulse that carries the tag once the write has landed in memory. A write with relaxed ordering may pass anything and is issued as soon as a port is free. A write with only ID ordering waits while an outstanding write has its requester ID. A write with neither flag waits until the scoreboard is empty. A write that must wait stalls the input through valid/ready, and nothing behind it is reordered past it. A typical stream is payload writes marked relaxed, followed by a strongly ordered completion flag. The payload spreads over both ports, and the flag is held until all the payload has been retired.

Top module: `pw_order_dispatch`

## Requirements
- R1: A write with both ordering flags clear is accepted (in_ready high) only when no earlier write is outstanding. An outstanding write is one accepted and not yet retired. Otherwise in_ready stays low and the write stays at the input.
- R2: A write with the relaxed flag set and the ID flag clear is accepted whenever a port can take it and the scoreboard is not full, whatever is outstanding.
- R3: A write with the ID flag set and the relaxed flag clear is accepted only when no outstanding write has the same requester ID. Outstanding writes from other requester IDs do not hold it back.
- R4: A write with both flags set follows the relaxed rule of R2.
- R5: A port can take a write when its valid output is low or its ready input is high. If only one port can take it, that port gets the write. If both can, the port with fewer outstanding writes gets it, and a tie goes to port 0.
- R6: An accepted write appears on the chosen port's valid, requester ID, address, length and tag outputs on the next clock, with its fields unchanged. It is held stable while that port's ready is low.
- R7: A write stays outstanding until the port it was sent on raises its retire valid with that write's tag. A retire pulse on the other port, or one with a tag that is not outstanding, has no effect.
- R8: At most DEPTH (16) writes are outstanding. With DEPTH outstanding, in_ready is low for every kind of write.
- R9: While rst is high at a clock edge, both port valid outputs go low on that edge and the scoreboard empties. A strongly ordered write is accepted at once after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Input descriptor accepted this cycle |
| in_ro | input | 1 | Relaxed-ordering flag |
| in_ido | input | 1 | ID-ordering flag |
| in_rid | input | RID_W | Requester ID |
| in_addr | input | ADDR_W | Write address |
| in_len | input | LEN_W | Write length |
| in_tag | input | TAG_W | Transaction tag, unique among outstanding writes |
| out_valid | output | 2 | Per-port descriptor valid (bit p for port p) |
| out_ready | input | 2 | Per-port ready |
| out_rid | output | 2*RID_W | Per-port requester ID, port p in slice p |
| out_addr | output | 2*ADDR_W | Per-port address |
| out_len | output | 2*LEN_W | Per-port length |
| out_tag | output | 2*TAG_W | Per-port tag |
| ret_valid | input | 2 | Per-port retire pulse |
| ret_tag | input | 2*TAG_W | Per-port retired tag |

## Verification
The in_ready decision has no delay. It depends on the present input descriptor, the port ready lines and the scoreboard as it stood at the last edge. The bench therefore drives its inputs at the falling edge and compares in_ready one time step later in the same half cycle. A descriptor that is accepted is due on its port's outputs one edge later. A retire pulse takes effect on the scoreboard at that same edge, so it can change in_ready from the following cycle onward. The reference model applies each edge's effects in exactly that order and compares every output at every falling edge.

// File: rtl/pwo_pkg.sv
package pwo_pkg;

  typedef enum logic [1:0] {
    ORD_STRONG  = 2'd0,
    ORD_BY_ID   = 2'd1,
    ORD_RELAXED = 2'd2
  } ord_class_e;

  // Relaxed ordering wins when both flags are present.
  function automatic ord_class_e classify(input logic ro, input logic ido);
    if (ro)       return ORD_RELAXED;
    else if (ido) return ORD_BY_ID;
    else          return ORD_STRONG;
  endfunction

endpackage

// File: rtl/pwo_scoreboard.sv
module pwo_scoreboard #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 5,
  parameter int RID_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic [TAG_W-1:0]   alloc_tag,
  input  logic [RID_W-1:0]   alloc_rid,
  input  logic               alloc_port,
  input  logic [1:0]         ret_valid,
  input  logic [2*TAG_W-1:0] ret_tag,
  input  logic [RID_W-1:0]   q_rid,
  output logic               rid_hit,
  output logic               empty,
  output logic               full,
  output logic [CNT_W-1:0]   cnt0,
  output logic [CNT_W-1:0]   cnt1
);

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] port_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [RID_W-1:0] rid_q [DEPTH];
  logic [IDX_W-1:0] alloc_idx;
  logic [CNT_W-1:0] total;

  // Lowest free slot.
  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) alloc_idx = IDX_W'(i);
  end

  always_comb begin
    rid_hit = 1'b0;
    total   = '0;
    cnt0    = '0;
    cnt1    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && rid_q[i] == q_rid) rid_hit = 1'b1;
      if (vld[i]) begin
        total = total + 1'b1;
        if (port_q[i]) cnt1 = cnt1 + 1'b1;
        else           cnt0 = cnt0 + 1'b1;
      end
    end
    empty = (vld == '0);
    full  = (total == CNT_W'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (vld[i] && ret_valid[0] && !port_q[i] && tag_q[i] == ret_tag[TAG_W-1:0])
          vld[i] <= 1'b0;
        if (vld[i] && ret_valid[1] && port_q[i] && tag_q[i] == ret_tag[2*TAG_W-1:TAG_W])
          vld[i] <= 1'b0;
        if (alloc_en && alloc_idx == IDX_W'(i))
          vld[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_en && alloc_idx == IDX_W'(i)) begin
        tag_q[i]  <= alloc_tag;
        rid_q[i]  <= alloc_rid;
        port_q[i] <= alloc_port;
      end
    end
  end

endmodule

// File: rtl/pwo_steer.sv
module pwo_steer #(
  parameter int CNT_W = 5
) (
  input  logic             ro,
  input  logic             ido,
  input  logic             rid_hit,
  input  logic             empty,
  input  logic             full,
  input  logic [1:0]       free,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  output logic             ok,
  output logic             sel
);
  import pwo_pkg::*;

  logic eligible;

  always_comb begin
    unique case (classify(ro, ido))
      ORD_RELAXED: eligible = 1'b1;
      ORD_BY_ID:   eligible = !rid_hit;
      default:     eligible = empty;
    endcase
    ok  = eligible && !full && (free != 2'b00);
    sel = (free == 2'b11) ? (cnt1 < cnt0) : !free[0];
  end

endmodule

// File: rtl/pwo_port_reg.sv
module pwo_port_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         free,
  output logic         valid,
  output logic [W-1:0] dout
);

  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end

endmodule

// File: rtl/pw_order_dispatch.sv
module pw_order_dispatch #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 5,
  parameter int RID_W  = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_ro,
  input  logic                in_ido,
  input  logic [RID_W-1:0]    in_rid,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [LEN_W-1:0]    in_len,
  input  logic [TAG_W-1:0]    in_tag,
  output logic [1:0]          out_valid,
  input  logic [1:0]          out_ready,
  output logic [2*RID_W-1:0]  out_rid,
  output logic [2*ADDR_W-1:0] out_addr,
  output logic [2*LEN_W-1:0]  out_len,
  output logic [2*TAG_W-1:0]  out_tag,
  input  logic [1:0]          ret_valid,
  input  logic [2*TAG_W-1:0]  ret_tag
);

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int DESC_W = RID_W + ADDR_W + LEN_W + TAG_W;

  logic             accept, sel, ok;
  logic             rid_hit, sb_empty, sb_full;
  logic [CNT_W-1:0] cnt0, cnt1;
  logic [1:0]       free;
  logic [DESC_W-1:0] in_desc;

  assign in_desc  = {in_rid, in_addr, in_len, in_tag};
  assign in_ready = ok;
  assign accept   = in_valid && ok;

  pwo_scoreboard #(.DEPTH(DEPTH), .TAG_W(TAG_W), .RID_W(RID_W)) u_sb (
    .clk(clk), .rst(rst),
    .alloc_en(accept), .alloc_tag(in_tag), .alloc_rid(in_rid), .alloc_port(sel),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .q_rid(in_rid),
    .rid_hit(rid_hit), .empty(sb_empty), .full(sb_full), .cnt0(cnt0), .cnt1(cnt1)
  );

  pwo_steer #(.CNT_W(CNT_W)) u_steer (
    .ro(in_ro), .ido(in_ido), .rid_hit(rid_hit), .empty(sb_empty), .full(sb_full),
    .free(free), .cnt0(cnt0), .cnt1(cnt1), .ok(ok), .sel(sel)
  );

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [DESC_W-1:0] dq;

    pwo_port_reg #(.W(DESC_W)) u_reg (
      .clk(clk), .rst(rst),
      .load(accept && (sel == 1'(p))), .din(in_desc), .ready(out_ready[p]),
      .free(free[p]), .valid(out_valid[p]), .dout(dq)
    );

    assign out_rid [p*RID_W  +: RID_W ] = dq[DESC_W-1 -: RID_W];
    assign out_addr[p*ADDR_W +: ADDR_W] = dq[LEN_W+TAG_W +: ADDR_W];
    assign out_len [p*LEN_W  +: LEN_W ] = dq[TAG_W +: LEN_W];
    assign out_tag [p*TAG_W  +: TAG_W ] = dq[0 +: TAG_W];
  end

endmodule

// File: rtl/pwo_checker.sv
module pwo_checker #(
  parameter int TAG_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_ro,
  input logic               in_ido,
  input logic               sb_empty,
  input logic               sb_full,
  input logic               rid_hit,
  input logic [1:0]         out_valid,
  input logic [1:0]         out_ready,
  input logic [2*TAG_W-1:0] out_tag
);

  AST_STRONG_WAITS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_ro && !in_ido) |-> sb_empty); // R1

  AST_RELAXED_GOES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ro && !sb_full && (!out_valid[0] || out_ready[0])) |-> in_ready); // R2

  AST_ID_NO_SAME_RID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_ido && !in_ro) |-> !rid_hit); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> !sb_full); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (out_valid == 2'b00)); // R9

  for (genvar p = 0; p < 2; p++) begin : g_hold
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (out_valid[p] && !out_ready[p]) |=> (out_valid[p] && $stable(out_tag[p*TAG_W +: TAG_W]))); // R6
  end

endmodule

bind pw_order_dispatch pwo_checker #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_ro(in_ro), .in_ido(in_ido), .sb_empty(sb_empty), .sb_full(sb_full),
  .rid_hit(rid_hit), .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag)
);

// File: tb/tb_pw_order_dispatch.sv
module tb_pw_order_dispatch;
  localparam int DEPTH = 16, TAG_W = 5, RID_W = 8, ADDR_W = 32, LEN_W = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst, in_valid, in_ready, in_ro, in_ido;
  logic [RID_W-1:0]    in_rid;
  logic [ADDR_W-1:0]   in_addr;
  logic [LEN_W-1:0]    in_len;
  logic [TAG_W-1:0]    in_tag;
  logic [1:0]          out_valid, out_ready, ret_valid;
  logic [2*RID_W-1:0]  out_rid;
  logic [2*ADDR_W-1:0] out_addr;
  logic [2*LEN_W-1:0]  out_len;
  logic [2*TAG_W-1:0]  out_tag, ret_tag;

  pw_order_dispatch #(.DEPTH(DEPTH), .TAG_W(TAG_W), .RID_W(RID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_ro(in_ro), .in_ido(in_ido),
    .in_rid(in_rid), .in_addr(in_addr), .in_len(in_len), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_rid(out_rid), .out_addr(out_addr),
    .out_len(out_len), .out_tag(out_tag), .ret_valid(ret_valid), .ret_tag(ret_tag));

  typedef struct { int tag; int rid; int port; } ent_t;
  ent_t sb[$];
  int   cmt0[$], cmt1[$];
  int   nvec = 0, nerr = 0;

  bit m_ov[2];
  int m_tag[2], m_rid[2], m_len[2];
  logic [ADDR_W-1:0] m_addr[2];

  bit h_v, h_ro, h_ido;
  int h_rid, h_tag, h_len, next_tag, seq;
  logic [ADDR_W-1:0] h_addr;
  int mode;
  bit ret_en, wrong_port;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit tag_busy(int t);
    foreach (sb[i]) if (sb[i].tag == t) return 1;
    return 0;
  endfunction

  task automatic new_head();
    int k;
    k = seq % 9;
    case (mode)
      1: begin h_ro = (k != 8); h_ido = 0; h_rid = 3; end          // payload then flag
      2: begin h_ro = 0; h_ido = 1; h_rid = int'($urandom % 3); end
      3: begin h_ro = 1; h_ido = int'($urandom % 2); h_rid = 1; end // fill
      4: begin h_ro = 0; h_ido = 0; h_rid = 0; end                  // strong right after reset
      default: begin h_ro = $urandom % 2; h_ido = $urandom % 2; h_rid = int'($urandom % 4); end
    endcase
    while (tag_busy(next_tag)) next_tag = (next_tag + 1) % 32;
    h_tag = next_tag; next_tag = (next_tag + 1) % 32;
    h_addr = ADDR_W'($urandom); h_len = int'($urandom % 1024);
    h_v = 1; seq++;
  endtask

  task automatic step();
    bit exp_rdy, elig, full, any_same, acc, sel;
    bit fr[2];
    int c[2];
    string lbl;
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(out_valid[p] == m_ov[p], "R5", $sformatf("out_valid[%0d]", p), out_valid[p], m_ov[p]);
      if (m_ov[p] && out_valid[p]) begin
        chk(out_tag[p*TAG_W +: TAG_W] == TAG_W'(m_tag[p]), "R6", "tag", out_tag[p*TAG_W +: TAG_W], m_tag[p]);
        chk(out_rid[p*RID_W +: RID_W] == RID_W'(m_rid[p]), "R6", "rid", out_rid[p*RID_W +: RID_W], m_rid[p]);
        chk(out_addr[p*ADDR_W +: ADDR_W] == m_addr[p], "R6", "addr", out_addr[p*ADDR_W +: ADDR_W], m_addr[p]);
        chk(out_len[p*LEN_W +: LEN_W] == LEN_W'(m_len[p]), "R6", "len", out_len[p*LEN_W +: LEN_W], m_len[p]);
      end
    end
    if (!h_v) new_head();
    in_valid = h_v; in_ro = h_ro; in_ido = h_ido; in_rid = RID_W'(h_rid);
    in_tag = TAG_W'(h_tag); in_addr = h_addr; in_len = LEN_W'(h_len);
    out_ready = 2'($urandom);
    ret_valid = 2'b00; ret_tag = '0; wrong_port = 0;
    for (int p = 0; p < 2; p++) begin
      int r = int'($urandom % 4);
      if (ret_en && r < 2 && p == 0 && cmt0.size() > 0) begin
        ret_valid[0] = 1; ret_tag[TAG_W-1:0] = TAG_W'(cmt0.pop_front());
      end else if (ret_en && r < 2 && p == 1 && cmt1.size() > 0) begin
        ret_valid[1] = 1; ret_tag[2*TAG_W-1:TAG_W] = TAG_W'(cmt1.pop_front());
      end else if (r == 2 && p == 0 && cmt1.size() > 0) begin
        ret_valid[0] = 1; ret_tag[TAG_W-1:0] = TAG_W'(cmt1[0]); wrong_port = 1; // R7 ignored
      end else if (r == 2 && p == 1 && cmt0.size() > 0) begin
        ret_valid[1] = 1; ret_tag[2*TAG_W-1:TAG_W] = TAG_W'(cmt0[0]); wrong_port = 1; // R7 ignored
      end
    end
    #1;
    c[0] = 0; c[1] = 0; any_same = 0;
    foreach (sb[i]) begin
      c[sb[i].port]++;
      if (sb[i].rid == h_rid) any_same = 1;
    end
    full = (sb.size() >= DEPTH);
    if (h_ro)       begin elig = 1;         lbl = h_ido ? "R4" : "R2"; end
    else if (h_ido) begin elig = !any_same; lbl = "R3"; end
    else            begin elig = (sb.size() == 0); lbl = wrong_port ? "R7" : "R1"; end
    if (full) lbl = wrong_port ? "R7" : "R8";
    for (int p = 0; p < 2; p++) fr[p] = !m_ov[p] || out_ready[p];
    exp_rdy = elig && !full && (fr[0] || fr[1]);
    chk(in_ready == exp_rdy, lbl, "in_ready", in_ready, exp_rdy);
    sel = (fr[0] && fr[1]) ? (c[1] < c[0]) : !fr[0];
    acc = h_v && exp_rdy;
    for (int p = 0; p < 2; p++) begin
      if (ret_valid[p]) begin
        int t = int'(ret_tag[p*TAG_W +: TAG_W]);
        foreach (sb[i]) if (sb[i].tag == t && sb[i].port == p) begin sb.delete(i); break; end
      end
      if (m_ov[p] && out_ready[p]) begin
        if (p == 0) cmt0.push_back(m_tag[0]); else cmt1.push_back(m_tag[1]);
        m_ov[p] = 0;
      end
    end
    if (acc) begin
      ent_t e;
      e.tag = h_tag; e.rid = h_rid; e.port = int'(sel);
      sb.push_back(e);
      m_ov[sel] = 1; m_tag[sel] = h_tag; m_rid[sel] = h_rid; m_addr[sel] = h_addr; m_len[sel] = h_len;
      h_v = 0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst = 1; in_valid = 0; in_ro = 0; in_ido = 0; in_rid = '0; in_addr = '0; in_len = '0; in_tag = '0;
    out_ready = 2'b11; ret_valid = 2'b00; ret_tag = '0;
    h_v = 0; next_tag = 0; seq = 0; ret_en = 1; mode = 4;
    m_ov[0] = 0; m_ov[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 2'b00, "R9", "out_valid in reset", out_valid, 0);
    rst = 0;
    step();  // R9: strong write accepted at once after reset
    mode = 0; repeat (1500) step();
    mode = 1; seq = 0; repeat (600) step();
    mode = 2; repeat (400) step();
    mode = 3; ret_en = 0; repeat (60) step();   // R8 fill, R7 wrong-port pulses only
    ret_en = 1; repeat (200) step();
    mode = 0; repeat (300) step();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule